// File: doc/BRIEF.md
# VCO Sub-Band Calibration Sequencer

Before the frequency loop is closed, the oscillator must be placed in the correct coarse sub-band. This block does that placement. It controls a 5-bit sub-band code and measures the oscillator at each trial setting. For each measurement it counts divided-oscillator ticks over one period of the divided reference, which is the phase-detector comparison period. It then compares that count with a programmed target and settles the code one bit at a time, starting from the most significant bit.

A run takes seven comparison periods:

- one period to let the oscillator settle;
- five trial periods;
- one closing period.

While the run is in progress, the block raises a busy flag. It also raises a force-midrail output that parks the charge pump and the control voltage at half supply.

A run starts in one of two ways:

- a one-clock start pulse, produced by software writing the calibration-trigger bit;
- a write of a new division ratio, but only when the auto-restart enable is set.

The busy flag serves as the read-back value of the trigger bit. When the run finishes, busy clears itself and a one-clock done pulse is emitted.

The sequencer has four states:

- `ST_IDLE`: waits for a start. The transition `go` leads to `ST_SETTLE` and loads the trial code with only the MSB set.
- `ST_SETTLE`: on a reference tick, moves to `ST_TRIAL`.
- `ST_TRIAL`: on each reference tick, decides the current trial bit and sets the next lower bit. After the LSB has been decided, it moves to `ST_FINAL`.
- `ST_FINAL`: on a reference tick, returns to `ST_IDLE` and pulses done.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, band is 0 and busy, force_mid and done are all 0.
- R2: A start in idle, meaning cal_start high or ratio_wr high with auto_en high, makes busy 1 in the next cycle with band = 5'b10000.
- R3: Busy falls, and done pulses, in the cycle after the 7th ref_tick that follows the start: 1 settle period, then 5 trial periods from MSB to LSB, then 1 final period.
- R4: A trial period is counted from the cycle after the ref_tick that opens it, up to and including the ref_tick that closes it. If the osc_tick count exceeds target_cnt, the trial bit is cleared; otherwise it is kept. For an oscillator that rises monotonically with the code, the result is the largest code whose count is at most target_cnt, or 0 if no code meets that.
- R5: force_mid equals busy in every cycle.
- R6: done is high for exactly one cycle, and only in the cycle where busy has just fallen. band holds its value after done.
- R7: A start that arrives while busy is ignored. The run's timing and its result are unchanged.
- R8: ratio_wr with auto_en low does not start a run.
- R9: band changes only on a ref_tick during a run, or when a run starts. It stays constant while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | One-clock pulse from a write of the trigger bit |
| auto_en | input | 1 | Enables a restart on a division-ratio write |
| ratio_wr | input | 1 | One-clock pulse when a new division ratio is written |
| osc_tick | input | 1 | One-clock pulse for each divided-oscillator edge |
| ref_tick | input | 1 | One-clock pulse for each comparison period |
| target_cnt | input | CNT_W | Expected oscillator count per comparison period |
| band | output | BAND_W | Sub-band code |
| busy | output | 1 | Run in progress; read-back value of the trigger bit |
| force_mid | output | 1 | Parks the charge pump and control voltage at mid-supply |
| done | output | 1 | One-clock pulse at the end of a run |

## Verification
The bench models the oscillator as a source that emits 8 + 2*code ticks per reference period. It runs calibrations against directed targets:

- below the lowest count, which shows the search bottoming out at code 0;
- exactly on a count and just above one, which tells `>` apart from `>=` in the decision;
- at and above the highest count, which checks saturation at 31.

Random targets follow and cover every bit-decision path. Further runs exercise the remaining behaviours:

- a stray start injected mid-run, which must leave both the run length and the result unchanged;
- auto-restart with the enable both on and off, which tells the gated trigger apart from an ungated one.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_TRIAL,
        ST_FINAL
    } cal_state_t;
endpackage

// File: rtl/vbc_win_cnt.sv
module vbc_win_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] measured
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // count including the current cycle's tick, saturating
    always_comb begin
        if (tick && cnt_q != CNT_MAX)
            measured = cnt_q + 1'b1;
        else
            measured = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else
            cnt_q <= measured;
    end
endmodule

// File: rtl/vbc_sar.sv
module vbc_sar #(
    parameter int BAND_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              too_fast,
    output logic [BAND_W-1:0] band,
    output logic              last
);
    localparam logic [BAND_W-1:0] MSB_ONLY = {1'b1, {(BAND_W-1){1'b0}}};

    logic [BAND_W-1:0] trial_q;
    logic [BAND_W-1:0] drop;

    assign drop = too_fast ? trial_q : '0;
    assign last = trial_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band    <= '0;
            trial_q <= '0;
        end else if (load) begin
            band    <= MSB_ONLY;
            trial_q <= MSB_ONLY;
        end else if (step) begin
            band    <= (band & ~drop) | (trial_q >> 1);
            trial_q <= trial_q >> 1;
        end
    end
endmodule

// File: rtl/vbc_fsm.sv
module vbc_fsm
    import vbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ref_tick,
    input  logic last_bit,
    output logic load,
    output logic step,
    output logic busy,
    output logic force_mid,
    output logic done
);
    cal_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go)       state_d = ST_SETTLE;
            ST_SETTLE: if (ref_tick) state_d = ST_TRIAL;
            ST_TRIAL:  if (ref_tick && last_bit) state_d = ST_FINAL;
            ST_FINAL:  if (ref_tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            force_mid <= 1'b0;
            done      <= 1'b0;
        end else begin
            busy      <= (state_d != ST_IDLE);
            force_mid <= (state_d != ST_IDLE);
            done      <= (state_q == ST_FINAL) && ref_tick;
        end
    end

    assign load = (state_q == ST_IDLE) && go;
    assign step = (state_q == ST_TRIAL) && ref_tick;
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
    parameter int BAND_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              auto_en,
    input  logic              ratio_wr,
    input  logic              osc_tick,
    input  logic              ref_tick,
    input  logic [CNT_W-1:0]  target_cnt,
    output logic [BAND_W-1:0] band,
    output logic              busy,
    output logic              force_mid,
    output logic              done
);
    logic             go;
    logic             load;
    logic             step;
    logic             last_bit;
    logic [CNT_W-1:0] measured;
    logic             too_fast;

    assign go       = cal_start || (auto_en && ratio_wr);
    assign too_fast = measured > target_cnt;

    vbc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .ref_tick  (ref_tick),
        .last_bit  (last_bit),
        .load      (load),
        .step      (step),
        .busy      (busy),
        .force_mid (force_mid),
        .done      (done)
    );

    vbc_win_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ref_tick || load),
        .tick     (osc_tick),
        .measured (measured)
    );

    vbc_sar #(.BAND_W(BAND_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .too_fast (too_fast),
        .band     (band),
        .last     (last_bit)
    );
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
    parameter int BAND_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_start,
    input logic              auto_en,
    input logic              ratio_wr,
    input logic              ref_tick,
    input logic [BAND_W-1:0] band,
    input logic              busy,
    input logic              force_mid,
    input logic              done
);
    localparam logic [BAND_W-1:0] MSB_ONLY = {1'b1, {(BAND_W-1){1'b0}}};

    logic go;
    assign go = cal_start || (auto_en && ratio_wr);

    p_go_loads_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> (busy && band == MSB_ONLY));

    p_mid_tracks_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_mid == busy);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_start_busy_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_start && !ref_tick) |=> busy);

    p_band_ref_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && (busy || !go)) |=> $stable(band));
endmodule

bind vco_band_cal vbc_checker #(.BAND_W(BAND_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_start (cal_start),
    .auto_en   (auto_en),
    .ratio_wr  (ratio_wr),
    .ref_tick  (ref_tick),
    .band      (band),
    .busy      (busy),
    .force_mid (force_mid),
    .done      (done)
);

// File: tb/sim_vco_band_cal.sv
`timescale 1ns/1ps
module sim_vco_band_cal;
    localparam int BAND_W = 5;
    localparam int CNT_W  = 8;
    localparam int PERIOD = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0;
    logic auto_en = 1'b0;
    logic ratio_wr = 1'b0;
    logic osc_tick = 1'b0;
    logic ref_tick = 1'b0;
    logic [CNT_W-1:0] target_cnt = '0;
    logic [BAND_W-1:0] band;
    logic busy, force_mid, done;

    int checks = 0;
    int errors = 0;
    int phase = 0;
    int ref_count = 0;
    int cur_n = 8;

    always #2.5 clk = ~clk;

    vco_band_cal #(.BAND_W(BAND_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .auto_en(auto_en),
        .ratio_wr(ratio_wr), .osc_tick(osc_tick), .ref_tick(ref_tick),
        .target_cnt(target_cnt), .band(band), .busy(busy),
        .force_mid(force_mid), .done(done)
    );

    // oscillator model: 8 + 2*code ticks per reference period
    function automatic int osc_count(input int code);
        return 8 + 2 * code;
    endfunction

    function automatic int exp_band(input int tgt);
        int best = 0;
        for (int c = 0; c < 32; c++)
            if (osc_count(c) <= tgt) best = c;
        return best;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference / oscillator tick generator, driven on negedge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                phase = 0;
                osc_tick = 1'b0;
                ref_tick = 1'b0;
            end else begin
                if (phase == 0) cur_n = osc_count(int'(band));
                osc_tick = (phase >= 2) && (phase % 2 == 0) && (phase < 2 + 2 * cur_n);
                ref_tick = (phase == PERIOD - 1);
                if (ref_tick) ref_count++;
                phase = (phase == PERIOD - 1) ? 0 : phase + 1;
            end
        end
    end

    task automatic run_cal(input int tgt, input bit use_auto, input bit stray);
        int rc0;
        int waited = 0;
        int expb = exp_band(tgt);
        logic [BAND_W-1:0] held;
        while (phase != 40) @(negedge clk);
        target_cnt = CNT_W'(tgt);
        rc0 = ref_count;
        if (use_auto) begin auto_en = 1'b1; ratio_wr = 1'b1; end
        else cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0; ratio_wr = 1'b0;
        check(busy == 1'b1, use_auto ? "R8 auto start busy" : "R2 busy", int'(busy), 1);
        check(band == 5'b10000, "R2 band msb", int'(band), 16);
        while (!done && waited < 3000) begin
            if (force_mid != busy) check(1'b0, "R5 force_mid", int'(force_mid), int'(busy));
            if (stray && waited == 500) cal_start = 1'b1;
            if (stray && waited == 501) cal_start = 1'b0;
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R3 done seen", int'(done), 1);
        check(ref_count - rc0 == 7, stray ? "R7 periods" : "R3 periods", ref_count - rc0, 7);
        check(busy == 1'b0 && force_mid == 1'b0, "R6 busy low at done", int'(busy), 0);
        check(int'(band) == expb, stray ? "R7 result" : "R4 result", int'(band), expb);
        held = band;
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
        repeat (30) @(negedge clk);
        check(band == held && !busy, "R9 band stable idle", int'(band), int'(held));
        auto_en = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed = 17;
        int dummy;
        dummy = $urandom(seed);
        repeat (3) @(negedge clk);
        check(band == '0 && !busy && !force_mid && !done, "R1 reset state", int'(band), 0);
        rst_n = 1'b1;
        // directed corners (R4)
        run_cal(0, 1'b0, 1'b0);
        run_cal(7, 1'b0, 1'b0);
        run_cal(8, 1'b0, 1'b0);
        run_cal(9, 1'b0, 1'b0);
        run_cal(40, 1'b0, 1'b0);
        run_cal(41, 1'b0, 1'b0);
        run_cal(70, 1'b0, 1'b0);
        run_cal(71, 1'b0, 1'b0);
        run_cal(255, 1'b0, 1'b0);
        // stray start while busy (R7)
        run_cal(33, 1'b0, 1'b1);
        // auto restart (R8)
        run_cal(50, 1'b1, 1'b0);
        // ratio write without enable must not start (R8)
        while (phase != 40) @(negedge clk);
        auto_en = 1'b0; ratio_wr = 1'b1;
        @(negedge clk);
        ratio_wr = 1'b0;
        check(busy == 1'b0, "R8 no auto start", int'(busy), 0);
        repeat (PERIOD) @(negedge clk);
        check(busy == 1'b0 && band == 5'(exp_band(50)), "R8 band untouched", int'(band), exp_band(50));
        // random targets
        for (int i = 0; i < 25; i++)
            run_cal(int'($urandom_range(0, 90)), bit'($urandom_range(0, 1)), 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule